// File: doc/BRIEF.md
# AXI single-beat word bridge

This block is an AXI slave that turns single-beat transactions into accesses on a 32-bit, word-addressed register or SRAM port with byte write enables. Write strobes become per-lane write enables, so an 8-bit or 16-bit store changes only the lanes it strobes. Whatever the bus master leaves on the other lanes is never stored.

A transaction of more than one beat does not reach memory. It is still carried through to its end. A write burst has every W beat accepted up to WLAST and then gets one SLVERR response. A read burst returns one SLVERR beat for each requested beat, with zero data. Each direction keeps one transaction in flight. The read and write paths share the memory port, and the write wins when both ask for it in the same cycle.

All five AXI channels use valid/ready. A beat moves on a clock edge where both VALID and READY are high. The bridge keeps BVALID and RVALID, and all the fields that go with them, unchanged until the master raises the matching READY. AWREADY and ARREADY depend only on internal state, never on the incoming VALID. The memory port has no back-pressure. An access happens on every cycle that `mem_en` is high, and read data appears on `mem_rdata` one cycle later.

Top module: `axi_word_bridge`

## Requirements
- R1: The memory word address is byte address bits [ADDR_W-1:2]. The two low address bits have no effect on which word is accessed.
- R2: A single-beat write changes only the byte lanes whose WSTRB bit is 1 (bit b covers data bits 8b+7..8b). All other lanes of the target word, and all other words, keep their contents.
- R3: A single-beat write (AWLEN = 0) ends with one B response carrying BRESP = 2'b00 (OKAY) and BID equal to AWID.
- R4: A single-beat read (ARLEN = 0) returns the full 32-bit word, whatever access size the master intends. The beat carries RRESP = 2'b00, RID equal to ARID and RLAST = 1.
- R5: A write with AWLEN > 0 has every W beat accepted up to the one with WLAST, then ends with one B response carrying BRESP = 2'b10 (SLVERR) and the request's ID.
- R6: No data from a write with AWLEN > 0 is stored. All memory write enables stay low from its address handshake until its B handshake.
- R7: A read with ARLEN > 0 returns ARLEN+1 beats. Each beat carries RRESP = 2'b10, RDATA = 0 and the request's ID, and RLAST is 1 on the final beat only.
- R8: AWREADY stays low from an address handshake until the B handshake of that write. ARREADY stays low from an address handshake until the handshake of that read's last R beat.
- R9: While BVALID is high and BREADY is low, BVALID, BID and BRESP hold their values. While RVALID is high and RREADY is low, RVALID, RID, RDATA, RRESP and RLAST hold their values.
- R10: When the write and read paths request the memory port in the same cycle, the write is performed first. A read of the same word then returns the newly written data.
- R11: After reset, AWREADY and ARREADY are 1, BVALID, RVALID and `mem_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awid | input | ID_W | Write transaction ID |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awlen | input | LEN_W | Write beats minus one |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte lane strobes |
| s_wlast | input | 1 | Final write beat |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_arid | input | ID_W | Read transaction ID |
| s_araddr | input | ADDR_W | Read byte address |
| s_arlen | input | LEN_W | Read beats minus one |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rid | output | ID_W | Read response ID |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Final read beat |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 4 | Per-byte write enables |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after access |

## Verification
The hardest case to reach from the ports is both paths asking for the memory port in the same cycle. The write path reaches its memory request two edges after its address is accepted, while a read reaches its request one edge after its address. The stimulus therefore starts a write and, one clock later, issues a read of the same word, so that the read address handshake lands on the same edge as the W beat. Only the write-first order returns the new data. A second stress point is an error burst running while its data lanes carry values that would corrupt memory; the memory contents are compared against the reference on every clock.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {WS_ADDR, WS_DATA, WS_MEM, WS_RESP} wr_state_e;
  typedef enum logic [2:0] {RS_ADDR, RS_MEM, RS_WAIT, RS_DATA, RS_ERR} rd_state_e;
endpackage

// File: rtl/bridge_wr.sv
module bridge_wr
  import bridge_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int WA_W  = 10,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ID_W-1:0]   awid,
  input  logic [WA_W-1:0]   awaddr,
  input  logic [LEN_W-1:0]  awlen,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wlast,
  output logic              bvalid,
  input  logic              bready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  output logic              req,
  input  logic              gnt,
  output logic [WA_W-1:0]   addr,
  output logic [DATA_W-1:0] data,
  output logic [STRB_W-1:0] strb
);
  wr_state_e         st;
  logic [ID_W-1:0]   id_q;
  logic [WA_W-1:0]   addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              err_q;

  assign awready = (st == WS_ADDR);
  assign wready  = (st == WS_DATA);
  assign req     = (st == WS_MEM);
  assign bvalid  = (st == WS_RESP);
  assign bid     = id_q;
  assign bresp   = err_q ? RESP_SLVERR : RESP_OKAY;
  assign addr    = addr_q;
  assign data    = data_q;
  assign strb    = strb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= WS_ADDR;
      id_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        WS_ADDR: if (awvalid) begin
          id_q   <= awid;
          addr_q <= awaddr;
          err_q  <= (awlen != '0);
          st     <= WS_DATA;
        end
        WS_DATA: if (wvalid) begin
          if (err_q) begin
            // error burst: drain beats, keep nothing
            if (wlast) st <= WS_RESP;
          end else begin
            data_q <= wdata;
            strb_q <= wstrb;
            st     <= WS_MEM;
          end
        end
        WS_MEM:  if (gnt) st <= WS_RESP;
        WS_RESP: if (bready) st <= WS_ADDR;
        default: st <= WS_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/bridge_rd.sv
module bridge_rd
  import bridge_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int WA_W  = 10,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [WA_W-1:0]   araddr,
  input  logic [LEN_W-1:0]  arlen,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic              req,
  input  logic              gnt,
  output logic [WA_W-1:0]   addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  rd_state_e         st;
  logic [ID_W-1:0]   id_q;
  logic [WA_W-1:0]   addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;

  assign arready = (st == RS_ADDR);
  assign req     = (st == RS_MEM);
  assign rvalid  = (st == RS_DATA) || (st == RS_ERR);
  assign rid     = id_q;
  assign rdata   = data_q;
  assign rresp   = (st == RS_ERR) ? RESP_SLVERR : RESP_OKAY;
  assign rlast   = (st == RS_DATA) || ((st == RS_ERR) && (left_q == '0));
  assign addr    = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RS_ADDR;
      id_q   <= '0;
      addr_q <= '0;
      left_q <= '0;
      data_q <= '0;
    end else begin
      case (st)
        RS_ADDR: if (arvalid) begin
          id_q   <= arid;
          addr_q <= araddr;
          left_q <= arlen;
          if (arlen != '0) begin
            data_q <= '0;
            st     <= RS_ERR;
          end else begin
            st <= RS_MEM;
          end
        end
        RS_MEM:  if (gnt) st <= RS_WAIT;
        RS_WAIT: begin
          data_q <= mem_rdata;
          st     <= RS_DATA;
        end
        RS_DATA: if (rready) st <= RS_ADDR;
        RS_ERR:  if (rready) begin
          if (left_q == '0) st <= RS_ADDR;
          else              left_q <= left_q - 1'b1;
        end
        default: st <= RS_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/bridge_mem_arb.sv
module bridge_mem_arb
  import bridge_pkg::*;
#(
  parameter int WA_W = 10
) (
  input  logic              wr_req,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic              rd_req,
  input  logic [WA_W-1:0]   rd_addr,
  output logic              wr_gnt,
  output logic              rd_gnt,
  output logic              mem_en,
  output logic [STRB_W-1:0] mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  // write path has priority on the shared port
  assign wr_gnt    = wr_req;
  assign rd_gnt    = rd_req && !wr_req;
  assign mem_en    = wr_req || rd_req;
  assign mem_addr  = wr_req ? wr_addr : rd_addr;
  assign mem_wdata = wr_data;

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign mem_we[b] = wr_req && wr_strb[b];
  end
endmodule

// File: rtl/axi_word_bridge.sv
module axi_word_bridge
  import bridge_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              mem_en,
  output logic [3:0]        mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int WA_W = ADDR_W - 2;

  logic              wr_req, wr_gnt, rd_req, rd_gnt;
  logic [WA_W-1:0]   wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic              lo_bits_unused;

  // byte offset inside a word never selects anything
  assign lo_bits_unused = ^{s_awaddr[1:0], s_araddr[1:0]};

  bridge_wr #(.ID_W(ID_W), .WA_W(WA_W), .LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awid(s_awid),
    .awaddr(s_awaddr[ADDR_W-1:2]), .awlen(s_awlen),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
    .wstrb(s_wstrb), .wlast(s_wlast),
    .bvalid(s_bvalid), .bready(s_bready), .bid(s_bid), .bresp(s_bresp),
    .req(wr_req), .gnt(wr_gnt), .addr(wr_addr), .data(wr_data), .strb(wr_strb)
  );

  bridge_rd #(.ID_W(ID_W), .WA_W(WA_W), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(s_arvalid), .arready(s_arready), .arid(s_arid),
    .araddr(s_araddr[ADDR_W-1:2]), .arlen(s_arlen),
    .rvalid(s_rvalid), .rready(s_rready), .rid(s_rid), .rdata(s_rdata),
    .rresp(s_rresp), .rlast(s_rlast),
    .req(rd_req), .gnt(rd_gnt), .addr(rd_addr), .mem_rdata(mem_rdata)
  );

  bridge_mem_arb #(.WA_W(WA_W)) u_arb (
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_gnt(wr_gnt), .rd_gnt(rd_gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk
  import bridge_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             awvalid,
  input logic             awready,
  input logic [LEN_W-1:0] awlen,
  input logic             bvalid,
  input logic             bready,
  input logic [ID_W-1:0]  bid,
  input logic [1:0]       bresp,
  input logic             arready,
  input logic             rvalid,
  input logic             rready,
  input logic [ID_W-1:0]  rid,
  input logic [31:0]      rdata,
  input logic [1:0]       rresp,
  input logic             rlast,
  input logic [3:0]       mem_we
);
  logic err_burst_w;

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_burst_w <= 1'b0;
    else if (awvalid && awready)   err_burst_w <= (awlen != '0);
    else if (bvalid && bready)     err_burst_w <= 1'b0;
  end

  assert_burst_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_burst_w |-> (mem_we == 4'b0000));

  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready);

  assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready);

  assert_b_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));

  assert_r_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rid) && $stable(rdata)
                              && $stable(rresp) && $stable(rlast)));

  assert_okay_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rresp == RESP_OKAY) |-> rlast);

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rresp == RESP_SLVERR) |-> (rdata == 32'h0));
endmodule

bind axi_word_bridge bridge_chk #(.ID_W(ID_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .awvalid(s_awvalid), .awready(s_awready), .awlen(s_awlen),
  .bvalid(s_bvalid), .bready(s_bready), .bid(s_bid), .bresp(s_bresp),
  .arready(s_arready),
  .rvalid(s_rvalid), .rready(s_rready), .rid(s_rid), .rdata(s_rdata),
  .rresp(s_rresp), .rlast(s_rlast),
  .mem_we(mem_we)
);

// File: tb/tb_axi_word_bridge.sv
module tb_axi_word_bridge;
  localparam int ID_W      = 4;
  localparam int ADDR_W    = 12;
  localparam int LEN_W     = 8;
  localparam int MEM_WORDS = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              awvalid = 0, awready, wvalid = 0, wready, wlast = 0;
  logic [ID_W-1:0]   awid = '0, arid = '0, bid, rid;
  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic [LEN_W-1:0]  awlen = '0, arlen = '0;
  logic [31:0]       wdata = '0, rdata, mem_wdata;
  logic [3:0]        wstrb = '0, mem_we;
  logic              bvalid, bready = 0, arvalid = 0, arready, rvalid, rready = 0, rlast;
  logic [1:0]        bresp, rresp;
  logic              mem_en;
  logic [ADDR_W-3:0] mem_addr;
  logic [31:0]       mem_rdata;

  logic [31:0] sram    [MEM_WORDS];
  logic [31:0] ref_mem [MEM_WORDS];
  int  checks = 0, fails = 0;
  bit  wr_inflight = 0, err_w = 0, done = 0;

  axi_word_bridge #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awid(awid), .s_awaddr(awaddr), .s_awlen(awlen),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb), .s_wlast(wlast),
    .s_bvalid(bvalid), .s_bready(bready), .s_bid(bid), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_arid(arid), .s_araddr(araddr), .s_arlen(arlen),
    .s_rvalid(rvalid), .s_rready(rready), .s_rid(rid), .s_rdata(rdata), .s_rresp(rresp), .s_rlast(rlast),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] seed_word(input int i);
    return {16'hC0DE, 16'(i * 7)};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] st);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (st[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // behavioural SRAM on the memory port: one cycle read latency, read-first
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) sram[i] <= seed_word(i);
    end else if (mem_en) begin
      for (int b = 0; b < 4; b++)
        if (mem_we[b]) sram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      mem_rdata <= sram[mem_addr];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of memory contents and burst write enables
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (err_w) chk("R6", "write enable during error burst", 32'(mem_we), 32'h0);
      if (!wr_inflight) begin
        int bad;
        bad = -1;
        for (int i = 0; i < MEM_WORDS; i++)
          if (sram[i] !== ref_mem[i] && bad < 0) bad = i;
        checks++;
        if (bad >= 0) begin
          fails++;
          $display("FAIL R2 memory word %0d: actual %h expected %h", bad, sram[bad], ref_mem[bad]);
        end
      end
    end
  end

  task automatic do_write(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                          input logic [31:0] data, input logic [3:0] strb, input int len, input int bstall);
    string tag;
    tag = (len == 0) ? "R3" : "R5";
    wr_inflight = 1; err_w = (len != 0);
    awvalid = 1; awid = id; awaddr = addr; awlen = len[LEN_W-1:0];
    while (!awready) @(negedge clk);
    @(negedge clk); awvalid = 0;
    chk("R8", "awready while write open", 32'(awready), 32'h0);
    for (int b = 0; b <= len; b++) begin
      wvalid = 1; wdata = data + 32'(b); wstrb = strb; wlast = (b == len);
      while (!wready) @(negedge clk);
      @(negedge clk);
    end
    wvalid = 0; wlast = 0;
    bready = (bstall == 0);
    while (!bvalid) @(negedge clk);
    if (bstall > 0) begin
      logic [1:0] held;
      held = bresp;
      repeat (bstall) @(negedge clk);
      chk("R9", "bvalid held", 32'(bvalid), 32'h1);
      chk("R9", "bresp held", 32'(bresp), 32'(held));
      bready = 1;
    end
    chk(tag, "bid", 32'(bid), 32'(id));
    chk(tag, "bresp", 32'(bresp), (len == 0) ? 32'h0 : 32'h2);
    @(negedge clk); bready = 0;
    if (len == 0) ref_mem[addr[ADDR_W-1:2]] = merge(ref_mem[addr[ADDR_W-1:2]], data, strb);
    wr_inflight = 0; err_w = 0;
  endtask

  task automatic do_read(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr, input int len,
                         input logic [31:0] exp, input int stall, input string tag);
    string t;
    logic [31:0] held;
    t = (len == 0) ? tag : "R7";
    arvalid = 1; arid = id; araddr = addr; arlen = len[LEN_W-1:0];
    while (!arready) @(negedge clk);
    @(negedge clk); arvalid = 0;
    chk("R8", "arready while read open", 32'(arready), 32'h0);
    rready = (stall == 0);
    for (int b = 0; b <= len; b++) begin
      while (!rvalid) @(negedge clk);
      if (stall > 0 && b == 0) begin
        held = rdata;
        repeat (stall) @(negedge clk);
        chk("R9", "rvalid held", 32'(rvalid), 32'h1);
        chk("R9", "rdata held", rdata, held);
        rready = 1;
      end
      chk(t, "rid", 32'(rid), 32'(id));
      chk(t, "rresp", 32'(rresp), (len == 0) ? 32'h0 : 32'h2);
      chk(t, "rlast", 32'(rlast), 32'(b == len));
      chk(t, "rdata", rdata, (len == 0) ? exp : 32'h0);
      @(negedge clk);
    end
    rready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) ref_mem[i] = seed_word(i);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "awready", 32'(awready), 32'h1);
    chk("R11", "arready", 32'(arready), 32'h1);
    chk("R11", "bvalid", 32'(bvalid), 32'h0);
    chk("R11", "rvalid", 32'(rvalid), 32'h0);
    chk("R11", "mem_en", 32'(mem_en), 32'h0);

    // R3 / R4 full-word write and read-back
    do_write(4'h3, 12'h040, 32'hDEADBEEF, 4'hF, 0, 0);
    do_read(4'h5, 12'h040, 0, ref_mem[12'h040 >> 2], 0, "R4");

    // R2 narrow writes: garbage on unstrobed lanes
    do_write(4'h1, 12'h044, 32'hFFFF1234, 4'b0011, 0, 0);
    do_read(4'h2, 12'h044, 0, ref_mem[12'h044 >> 2], 0, "R2");
    do_write(4'h7, 12'h048, 32'h77AB7777, 4'b0100, 0, 0);
    do_read(4'h8, 12'h048, 0, ref_mem[12'h048 >> 2], 0, "R2");
    do_write(4'h9, 12'h04C, 32'h5500AA00, 4'b1010, 0, 0);
    do_read(4'h9, 12'h04C, 0, ref_mem[12'h04C >> 2], 0, "R2");

    // R1 low address bits ignored
    do_write(4'hA, 12'h053, 32'hA1B2C3D4, 4'hF, 0, 0);
    do_read(4'hB, 12'h050, 0, ref_mem[12'h050 >> 2], 0, "R1");
    do_read(4'hC, 12'h052, 0, ref_mem[12'h050 >> 2], 0, "R1");

    // R5 / R6 write burst drained, discarded
    do_write(4'h6, 12'h060, 32'hBAD0BAD0, 4'hF, 3, 0);
    do_read(4'h6, 12'h060, 0, ref_mem[12'h060 >> 2], 0, "R6");
    do_write(4'h2, 12'h064, 32'hBAD1BAD1, 4'hF, 1, 2);
    do_read(4'h2, 12'h064, 0, ref_mem[12'h064 >> 2], 0, "R6");

    // R7 read burst
    do_read(4'hD, 12'h040, 4, 32'h0, 0, "R7");
    do_read(4'hE, 12'h044, 1, 32'h0, 3, "R7");

    // R9 back-pressure on B and R
    do_write(4'h4, 12'h068, 32'h0BADF00D, 4'hF, 0, 3);
    do_read(4'h4, 12'h068, 0, ref_mem[12'h068 >> 2], 4, "R9");

    // R10 write and read contend for the memory port in the same cycle
    fork
      do_write(4'h1, 12'h070, 32'h11223344, 4'hF, 0, 0);
      begin
        @(negedge clk);
        do_read(4'h2, 12'h070, 0, merge(ref_mem[12'h070 >> 2], 32'h11223344, 4'hF), 0, "R10");
      end
    join
    @(negedge clk);

    // mixed strobes and offsets
    for (int i = 0; i < 6; i++) begin
      logic [ADDR_W-1:0] a;
      logic [3:0] s;
      a = 12'h100 + 12'(i * 4) + 12'(i % 4);
      s = (i == 5) ? 4'hF : 4'(1 << (i % 4));
      do_write(4'(i), a, 32'h5A5A0000 + 32'(i * 32'h01010101), s, 0, 0);
      do_read(4'(i + 1), {a[ADDR_W-1:2], 2'b00}, 0, ref_mem[a[ADDR_W-1:2]], 0, "R2");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule